// File: doc/BRIEF.md
# Column-Bypassing Array Multiplier

This block multiplies two unsigned N-bit operands with a carry-save array of full adders followed by a ripple-carry stage. The adders are arranged in columns, one column per multiplicand bit. When that bit is zero, every adder in the column is switched off. Its inputs are held at zero by gating, its carry output is zero, and its sum output passes on the sum from the adder above it. The result is still correct, because a zero multiplicand bit makes both the column's partial products and its incoming carries zero. Multiplicands with few one bits therefore cause less switching.

The operands are sampled on a clock edge where `start` is high. The product and a one-cycle `done` pulse appear one clock later. A new operation may start on every cycle. Next to the product, the block reports how many adder cells were enabled for that operation, so the bypass behaviour can be seen at the ports.

Top module: `cbm_mult`

## Requirements
- R1: While `rst_n` is low on a rising edge, the next state has `done` = 0, `product` = 0 and `active_cells` = 0. The reset is synchronous and has priority over `start`.
- R2: If `start` is high on rising edge E, `done` is high for exactly the cycle after edge E+1. It is not high in the cycle after edge E.
- R3: With `done` high, `product` equals the full 2N-bit unsigned product of the `mcand` and `mplier` values sampled with `start`.
- R4: Operations started on consecutive edges complete on consecutive edges, each with its own product.
- R5: With `start` low, `done` stays 0 and `product` and `active_cells` hold their values, whatever `mcand` and `mplier` do.
- R6: Each multiplicand bit j gates one column of N-1 adder cells. With `done` high, `active_cells` equals (N-1) × (number of one bits in the sampled `mcand`). The ripple stage is not counted.
- R7: A zero multiplicand gives product 0 with zero active cells. An all-ones multiplicand enables all N×(N-1) cells.
- R8: The final ripple stage never produces a carry beyond bit 2N-1, so the largest operands (2^N-1 squared) come out exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Sample the operands on this edge |
| mcand | input | N | Multiplicand; its bits gate the adder columns |
| mplier | input | N | Multiplier |
| product | output | 2N | Registered unsigned product |
| done | output | 1 | One-cycle pulse when `product` is updated |
| active_cells | output | clog2(N(N-1)+1) | Number of adder cells enabled for the last operation |

## Verification
The bench tries every operand pair at N=4, including 1010 × 1111, and random pairs at N=8. An adder that forwarded the wrong sum, or leaked a carry out of a bypassed column, would give wrong products exactly for the multiplicands that contain zero bits. Zero, all-ones and one-hot multiplicands exercise the edges of the bypass count, and the all-ones square exposes a ripple stage that drops its top carry. Back-to-back starts and idle stretches with changing inputs catch a `done` that is late or lasts two cycles, and a product register that reloads without `start`.

// File: rtl/cbm_pkg.sv
// Package: shared sizing helpers for the column-bypassing multiplier.
// Assumes operand widths of at least 2.
package cbm_pkg;

    // Width needed to count every adder cell of an n-bit array.
    function automatic int cnt_bits(input int n);
        return $clog2(n * (n - 1) + 1);
    endfunction

endpackage

// File: rtl/cbm_cell.sv
// Module: cbm_cell
// One full adder of the array with column bypass. col_en is the multiplicand
// bit of its column. When col_en is low, the adder inputs are held at zero
// by AND gating, the carry output is zero, and the sum output forwards s_in.
// Assumes that s_in, pp and c_in being consistent is the array's job.
module cbm_cell (
    input  logic col_en,
    input  logic mplier_bit,
    input  logic s_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out,
    output logic active
);
    logic g_pp, g_s, g_c, fa_s, fa_c;

    // Input gating: a disabled column sees only zeros.
    always_comb begin
        g_pp = col_en & mplier_bit;
        g_s  = col_en & s_in;
        g_c  = col_en & c_in;
    end

    // Full-adder core.
    always_comb begin
        fa_s = g_pp ^ g_s ^ g_c;
        fa_c = (g_pp & g_s) | (g_pp & g_c) | (g_s & g_c);
    end

    // Output selection: bypass forwards the upper sum and emits no carry.
    always_comb begin
        s_out  = col_en ? fa_s : s_in;
        c_out  = col_en & fa_c;
        active = col_en;
    end
endmodule

// File: rtl/cbm_array.sv
// Module: cbm_array
// Carry-save array of N-1 rows below the first partial-product row. Cell
// (i,j) has weight i+j. Its carry goes to cell (i+1,j), which belongs to the
// same multiplicand column, and its sum goes to cell (i+1,j-1). The leftmost
// cell of each row has no upper sum. Outputs are the low N product bits,
// the final-row sums and carries for the ripple stage, and the enable map.
// Assumes N >= 2.
module cbm_array #(
    parameter int N = 8,
    localparam int CELLS = N * (N - 1)
) (
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     b,
    output logic [N-1:0]     prod_lo,
    output logic [N-2:0]     fin_sum,
    output logic [N-1:0]     fin_carry,
    output logic [CELLS-1:0] active_map
);
    logic [N-1:0] s_row [N];
    logic [N-1:0] c_row [N];

    // Row 0: plain partial products, no carries yet.
    always_comb begin
        s_row[0] = a & {N{b[0]}};
        c_row[0] = '0;
    end

    genvar gi, gj;
    generate
        for (gi = 1; gi < N; gi++) begin : g_row
            for (gj = 0; gj < N; gj++) begin : g_col
                logic up_sum;
                if (gj < N - 1) begin : g_mid
                    assign up_sum = s_row[gi-1][gj+1];
                end else begin : g_left
                    assign up_sum = 1'b0;
                end
                cbm_cell u_cell (
                    .col_en     (a[gj]),
                    .mplier_bit (b[gi]),
                    .s_in       (up_sum),
                    .c_in       (c_row[gi-1][gj]),
                    .s_out      (s_row[gi][gj]),
                    .c_out      (c_row[gi][gj]),
                    .active     (active_map[(gi-1)*N + gj])
                );
            end
        end
        for (gi = 0; gi < N; gi++) begin : g_lo
            assign prod_lo[gi] = s_row[gi][0];
        end
        for (gj = 0; gj < N - 1; gj++) begin : g_fin
            assign fin_sum[gj] = s_row[N-1][gj+1];
        end
    endgenerate

    assign fin_carry = c_row[N-1];
endmodule

// File: rtl/cbm_ripple.sv
// Module: cbm_ripple
// W-bit ripple-carry adder that resolves the last carry-save row.
// Assumes the caller handles carry-in (it is zero here).
module cbm_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] cy;
    assign cy[0] = 1'b0;

    genvar gk;
    generate
        for (gk = 0; gk < W; gk++) begin : g_bit
            assign s[gk]    = x[gk] ^ y[gk] ^ cy[gk];
            assign cy[gk+1] = (x[gk] & y[gk]) | (x[gk] & cy[gk]) | (y[gk] & cy[gk]);
        end
    endgenerate

    assign cout = cy[W];
endmodule

// File: rtl/cbm_mult.sv
// Module: cbm_mult (top)
// Registered column-bypassing unsigned multiplier. Operands are captured
// when start is high. One cycle later the product, the enabled-cell count
// and a done pulse are registered. Assumes N >= 2. Reset is synchronous and
// active low.
module cbm_mult
    import cbm_pkg::*;
#(
    parameter int N = 8,
    localparam int PW = 2 * N,
    localparam int CW = cnt_bits(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  mcand,
    input  logic [N-1:0]  mplier,
    output logic [PW-1:0] product,
    output logic          done,
    output logic [CW-1:0] active_cells
);
    localparam int CELLS = N * (N - 1);

    logic [N-1:0]     op_a, op_b;
    logic             op_vld;
    logic [N-1:0]     lo_bits;
    logic [N-2:0]     fin_sum;
    logic [N-1:0]     fin_carry;
    logic [CELLS-1:0] act_map;
    logic [N-1:0]     hi_bits;
    logic             rip_cout;
    logic [CW-1:0]    act_cnt;

    // Operand capture stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a   <= '0;
            op_b   <= '0;
            op_vld <= 1'b0;
        end else begin
            op_vld <= start;
            if (start) begin
                op_a <= mcand;
                op_b <= mplier;
            end
        end
    end

    cbm_array #(.N(N)) u_array (
        .a          (op_a),
        .b          (op_b),
        .prod_lo    (lo_bits),
        .fin_sum    (fin_sum),
        .fin_carry  (fin_carry),
        .active_map (act_map)
    );

    cbm_ripple #(.W(N)) u_ripple (
        .x    ({1'b0, fin_sum}),
        .y    (fin_carry),
        .s    (hi_bits),
        .cout (rip_cout)
    );

    // Count the cells the array enabled for this operand pair.
    always_comb begin
        act_cnt = '0;
        for (int k = 0; k < CELLS; k++) begin
            act_cnt = act_cnt + CW'(act_map[k]);
        end
    end

    // Result stage: product, count and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product      <= '0;
            active_cells <= '0;
            done         <= 1'b0;
        end else begin
            done <= op_vld;
            if (op_vld) begin
                product      <= {hi_bits, lo_bits};
                active_cells <= act_cnt;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && product == '0 && active_cells == '0));

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ##1 done);

    // R5
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start ##1 !start) |=> !done);

    // R3
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == PW'($past(op_a)) * PW'($past(op_b)));

    // R6
    bypass_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |-> act_cnt == CW'((N - 1) * $countones(op_a)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |-> !rip_cout);
endmodule

// File: tb/test_cbm_mult.sv
// Directed bench: an 8-bit instance and a 4-bit instance on one 50 MHz clock.
module test_cbm_mult;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start8 = 1'b0, start4 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [15:0] p8;
    logic [7:0]  p4;
    logic        d8, d4;
    logic [5:0]  n8;
    logic [3:0]  n4;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    cbm_mult #(.N(8)) i_cbm_mult (
        .clk(clk), .rst_n(rst_n), .start(start8), .mcand(a8), .mplier(b8),
        .product(p8), .done(d8), .active_cells(n8));

    cbm_mult #(.N(4)) i_cbm_mult_w4 (
        .clk(clk), .rst_n(rst_n), .start(start4), .mcand(a4), .mplier(b4),
        .product(p4), .done(d4), .active_cells(n4));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One 8-bit operation, checked one cycle after the capture edge.
    task automatic op8(input logic [7:0] a, input logic [7:0] b, input string req);
        @(negedge clk); a8 = a; b8 = b; start8 = 1'b1;
        @(negedge clk); start8 = 1'b0;
        @(negedge clk);
        chk("R2", "done8", 32'(d8), 32'd1);
        chk(req, "product8", 32'(p8), 32'(16'(a) * 16'(b)));
        chk("R6", "cells8", 32'(n8), 32'(7 * $countones(a)));
    endtask

    task automatic op4(input logic [3:0] a, input logic [3:0] b, input string req);
        @(negedge clk); a4 = a; b4 = b; start4 = 1'b1;
        @(negedge clk); start4 = 1'b0;
        @(negedge clk);
        chk("R2", "done4", 32'(d4), 32'd1);
        chk(req, "product4", 32'(p4), 32'(8'(a) * 8'(b)));
        chk("R6", "cells4", 32'(n4), 32'(3 * $countones(a)));
    endtask

    // R1: reset clears outputs even with start held high.
    task automatic t_reset();
        rst_n = 1'b0; start8 = 1'b1; a8 = 8'hff; b8 = 8'hff;
        repeat (3) @(negedge clk);
        chk("R1", "done", 32'(d8), 32'd0);
        chk("R1", "product", 32'(p8), 32'd0);
        chk("R1", "cells", 32'(n8), 32'd0);
        start8 = 1'b0; rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R3, R6: the 1010 x 1111 pair and every other 4-bit pair.
    task automatic t_exhaustive4();
        op4(4'b1010, 4'b1111, "R3");
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                op4(4'(i), 4'(j), "R3");
    endtask

    // R7, R8: zero, all-ones and one-hot multiplicands.
    task automatic t_corners8();
        op8(8'h00, 8'hff, "R7");
        op8(8'hff, 8'hff, "R8");
        op8(8'hff, 8'h00, "R7");
        for (int k = 0; k < 8; k++) op8(8'(1 << k), 8'hb7, "R7");
    endtask

    task automatic t_random8();
        for (int k = 0; k < 200; k++) op8(8'($urandom), 8'($urandom), "R3");
    endtask

    // R4: starts on consecutive edges.
    task automatic t_back_to_back();
        @(negedge clk); a8 = 8'h5a; b8 = 8'hc3; start8 = 1'b1;
        @(negedge clk); a8 = 8'h81; b8 = 8'h7e;
        @(negedge clk); start8 = 1'b0; a8 = 8'h00; b8 = 8'h00;
        chk("R4", "done first", 32'(d8), 32'd1);
        chk("R4", "product first", 32'(p8), 32'(16'h5a * 16'hc3));
        @(negedge clk);
        chk("R4", "done second", 32'(d8), 32'd1);
        chk("R4", "product second", 32'(p8), 32'(16'h81 * 16'h7e));
        chk("R6", "cells second", 32'(n8), 32'd14);
        @(negedge clk);
        chk("R2", "done drops", 32'(d8), 32'd0);
    endtask

    // R5: inputs move while start is low; outputs hold.
    task automatic t_idle();
        logic [15:0] keep_p;
        logic [5:0]  keep_n;
        op8(8'hd3, 8'h2f, "R3");
        keep_p = p8; keep_n = n8;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); a8 = 8'($urandom); b8 = 8'($urandom);
            @(negedge clk);
            chk("R5", "done idle", 32'(d8), 32'd0);
            chk("R5", "product hold", 32'(p8), 32'(keep_p));
            chk("R5", "cells hold", 32'(n8), 32'(keep_n));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_exhaustive4();
        t_corners8();
        t_random8();
        t_back_to_back();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule